// File: doc/BRIEF.md
# Authenticated Indirect Branch Decode and Execute Unit

This unit recognises the 32-bit instruction words of the register-indirect branch group whose target must be authenticated before it is taken. When it accepts such a word it reads the target register and the modifier register through two combinational read ports. It then picks one of two keys and builds a 64-bit modifier, which is a register value, the stack pointer or zero. Target, modifier and key go out to an external authentication engine. The engine answers with a pass or fail result and, on pass, the authenticated address.

On pass the unit issues a one-cycle redirect. The redirect carries the authenticated address, a two-bit branch-type tag and a kind code that marks an unconditional indirect jump, which is neither a call nor a return. On fail it raises a one-cycle fault pulse and issues no redirect. A word that belongs to the group but is undefined raises a one-cycle undefined pulse and never reaches the engine. The unit has no register write port, so the authenticated address is never written back.

Back-pressure: the instruction input uses valid/ready and is accepted only while the unit is idle, with `insn_ready` high. The authentication request uses valid/ready. Once `auth_req_valid` rises, it stays high with key, target and modifier unchanged until a cycle in which `auth_req_ready` is high. After that, `auth_rsp_ready` is high until exactly one response has been taken. The redirect and the two pulses are plain single-cycle outputs.

Top module: `auth_ibranch_unit`

## Requirements
- R1: A word is in the group only when bits[31:25]=1101011, bit23=0, bits[22:21]=00, bits[20:16]=11111, bits[15:12]=0000 and bit11=1. An accepted word outside the group raises no request, no pulse and no redirect.
- R2: Bit 10 selects the key: 0 drives `auth_key_b`=0 (key A), and 1 drives `auth_key_b`=1 (key B).
- R3: Bit 24 selects the modifier. When it is 1 and bits[4:0]≠31, the modifier is `rs_data_m`. When it is 1 and bits[4:0]=31, the modifier is `sp_val`. When it is 0, the modifier is zero.
- R4: A group word accepted with `feat_en`=0, or with bit24=0 and bits[4:0]≠11111, pulses `undef_pulse` for one cycle, starting the cycle after acceptance, and raises no request.
- R5: The request becomes valid the cycle after acceptance. It stays valid with key, target and modifier stable until a cycle with `auth_req_ready`=1, and `insn_ready` stays low while the unit is busy.
- R6: After the request is taken, `auth_rsp_ready` stays high until one response is taken. A passing response gives a one-cycle `redir_valid` in the next cycle, with `redir_addr`=`auth_rsp_addr` and `redir_kind`=01 (unconditional indirect, not a call or return).
- R7: `redir_btype` is 01 when `guarded_pg` was 0 at acceptance. When it was 1, the tag is 01 for target register 16 or 17 and 11 for any other target register.
- R8: A failing response gives a one-cycle `fault_pulse` in the next cycle, with no redirect, and the unit returns to idle.
- R9: Synchronous active-high reset returns the unit to idle, with `insn_ready`=1 and all valids and pulses low, even in the middle of a request.
- R10: `rs_addr_t` is bits[9:5] and `rs_addr_m` is bits[4:0] of `insn_word`. The request target is `rs_data_t`, captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Authenticated branches enabled |
| guarded_pg | input | 1 | Current code page is guarded |
| insn_valid | input | 1 | Instruction word valid |
| insn_ready | output | 1 | Unit idle, word accepted |
| insn_word | input | 32 | Instruction word |
| rs_addr_t | output | 5 | Target register read address |
| rs_data_t | input | 64 | Target register read data |
| rs_addr_m | output | 5 | Modifier register read address |
| rs_data_m | input | 64 | Modifier register read data |
| sp_val | input | 64 | Stack pointer value |
| auth_req_valid | output | 1 | Authentication request valid |
| auth_req_ready | input | 1 | Engine takes request |
| auth_key_b | output | 1 | 0 key A, 1 key B |
| auth_target | output | 64 | Address to authenticate |
| auth_modifier | output | 64 | Modifier value |
| auth_rsp_valid | input | 1 | Response valid |
| auth_rsp_ready | output | 1 | Unit waiting for response |
| auth_rsp_pass | input | 1 | Authentication passed |
| auth_rsp_addr | input | 64 | Authenticated address |
| redir_valid | output | 1 | One-cycle redirect |
| redir_addr | output | 64 | Redirect address |
| redir_btype | output | 2 | Next branch-type tag |
| redir_kind | output | 2 | Branch kind, 01 = plain indirect |
| fault_pulse | output | 1 | Authentication failed |
| undef_pulse | output | 1 | Undefined group word |

## Verification
The four key and modifier combinations are each driven with distinct register contents. This separates a register modifier from a stack-pointer modifier and from a zero modifier, and key A from key B. Engine ready delays of zero and several cycles show that the request holds stable. Pass and fail responses tell the redirect path from the fault path. Target registers 16, 17 and others, with the guarded flag set and clear, cover every case of the tag. A clear feature bit, an illegal zero-modifier encoding, a word with one group bit flipped, and a reset during a pending request check the paths that must never reach the engine.

// File: rtl/aib_pkg.sv
package aib_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_WAIT = 2'd2} aib_state_e;

  typedef struct packed {
    logic       hit;
    logic       undef;
    logic       key_b;
    logic       reg_mod;
    logic       use_sp;
    logic [4:0] rn;
    logic [4:0] rm;
  } aib_dec_t;

  localparam logic [1:0] BTAG_PLAIN = 2'b01;
  localparam logic [1:0] BTAG_ANY   = 2'b11;
  localparam logic [1:0] KIND_INDIR = 2'b01;
endpackage

// File: rtl/aib_decode.sv
module aib_decode
  import aib_pkg::*;
(
  input  logic [31:0] word,
  input  logic        feat_en,
  output aib_dec_t    dec
);
  localparam logic [4:0] ZR = 5'h1f;

  logic match;
  assign match = (word[31:25] == 7'b1101011) && !word[23] &&
                 (word[22:21] == 2'b00) && (word[20:16] == ZR) &&
                 (word[15:12] == 4'h0) && word[11];

  always_comb begin
    dec.hit     = match;
    dec.key_b   = word[10];
    dec.reg_mod = word[24];
    dec.rn      = word[9:5];
    dec.rm      = word[4:0];
    dec.use_sp  = word[24] && (word[4:0] == ZR);
    dec.undef   = match && (!feat_en || (!word[24] && (word[4:0] != ZR)));
  end
endmodule

// File: rtl/aib_btag.sv
module aib_btag
  import aib_pkg::*;
#(
  parameter int RIDX_W  = 5,
  parameter int EXEMPT0 = 16,
  parameter int EXEMPT1 = 17
) (
  input  logic              guarded,
  input  logic [RIDX_W-1:0] rn,
  output logic [1:0]        tag
);
  localparam logic [RIDX_W-1:0] E0 = RIDX_W'(EXEMPT0);
  localparam logic [RIDX_W-1:0] E1 = RIDX_W'(EXEMPT1);

  always_comb begin
    if (guarded && (rn != E0) && (rn != E1)) tag = BTAG_ANY;
    else                                     tag = BTAG_PLAIN;
  end
endmodule

// File: rtl/aib_ctrl.sv
module aib_ctrl
  import aib_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            insn_valid,
  output logic            insn_ready,
  input  aib_dec_t        dec,
  input  logic [1:0]      btag_in,
  input  logic [XLEN-1:0] tgt_in,
  input  logic [XLEN-1:0] regmod_in,
  input  logic [XLEN-1:0] sp_in,
  output logic            req_valid,
  input  logic            req_ready,
  output logic            key_b,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] modifier,
  input  logic            rsp_valid,
  output logic            rsp_ready,
  input  logic            rsp_pass,
  input  logic [XLEN-1:0] rsp_addr,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_addr,
  output logic [1:0]      redir_btype,
  output logic            fault,
  output logic            undef
);
  aib_state_e      state;
  logic [1:0]      q_btag;
  logic [XLEN-1:0] mod_sel;
  logic            take;

  assign insn_ready = (state == ST_IDLE);
  assign req_valid  = (state == ST_REQ);
  assign rsp_ready  = (state == ST_WAIT);
  assign take       = insn_valid && insn_ready;

  always_comb begin
    if (!dec.reg_mod)    mod_sel = '0;
    else if (dec.use_sp) mod_sel = sp_in;
    else                 mod_sel = regmod_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      redir_valid <= 1'b0;
      fault       <= 1'b0;
      undef       <= 1'b0;
      key_b       <= 1'b0;
      target      <= '0;
      modifier    <= '0;
      q_btag      <= BTAG_PLAIN;
      redir_addr  <= '0;
      redir_btype <= BTAG_PLAIN;
    end else begin
      redir_valid <= 1'b0;
      fault       <= 1'b0;
      undef       <= 1'b0;
      unique case (state)
        ST_IDLE: if (take && dec.hit) begin
          if (dec.undef) undef <= 1'b1;
          else begin
            state    <= ST_REQ;
            key_b    <= dec.key_b;
            target   <= tgt_in;
            modifier <= mod_sel;
            q_btag   <= btag_in;
          end
        end
        ST_REQ: if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          state <= ST_IDLE;
          if (rsp_pass) begin
            redir_valid <= 1'b1;
            redir_addr  <= rsp_addr;
            redir_btype <= q_btag;
          end else begin
            fault <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(target) &&
                                   $stable(modifier) && $stable(key_b)));
  p_busy_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !insn_ready);
  p_undef_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    undef |-> !req_valid);
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (rst)
    !(fault && redir_valid));
  p_fault_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault);
  p_redir_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !redir_valid);
  p_btag_legal_r7: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> (redir_btype == BTAG_PLAIN || redir_btype == BTAG_ANY));
  p_rsp_once_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_ready && rsp_valid) |=> !rsp_ready);
endmodule

// File: rtl/auth_ibranch_unit.sv
module auth_ibranch_unit
  import aib_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              feat_en,
  input  logic              guarded_pg,
  input  logic              insn_valid,
  output logic              insn_ready,
  input  logic [31:0]       insn_word,
  output logic [RIDX_W-1:0] rs_addr_t,
  input  logic [XLEN-1:0]   rs_data_t,
  output logic [RIDX_W-1:0] rs_addr_m,
  input  logic [XLEN-1:0]   rs_data_m,
  input  logic [XLEN-1:0]   sp_val,
  output logic              auth_req_valid,
  input  logic              auth_req_ready,
  output logic              auth_key_b,
  output logic [XLEN-1:0]   auth_target,
  output logic [XLEN-1:0]   auth_modifier,
  input  logic              auth_rsp_valid,
  output logic              auth_rsp_ready,
  input  logic              auth_rsp_pass,
  input  logic [XLEN-1:0]   auth_rsp_addr,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_addr,
  output logic [1:0]        redir_btype,
  output logic [1:0]        redir_kind,
  output logic              fault_pulse,
  output logic              undef_pulse
);
  aib_dec_t   dec;
  logic [1:0] btag;

  aib_decode u_dec (.word(insn_word), .feat_en(feat_en), .dec(dec));

  assign rs_addr_t  = RIDX_W'(dec.rn);
  assign rs_addr_m  = RIDX_W'(dec.rm);
  assign redir_kind = KIND_INDIR;

  aib_btag #(.RIDX_W(RIDX_W)) u_btag (
    .guarded(guarded_pg), .rn(rs_addr_t), .tag(btag));

  aib_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .dec(dec), .btag_in(btag), .tgt_in(rs_data_t), .regmod_in(rs_data_m),
    .sp_in(sp_val), .req_valid(auth_req_valid), .req_ready(auth_req_ready),
    .key_b(auth_key_b), .target(auth_target), .modifier(auth_modifier),
    .rsp_valid(auth_rsp_valid), .rsp_ready(auth_rsp_ready),
    .rsp_pass(auth_rsp_pass), .rsp_addr(auth_rsp_addr),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .redir_btype(redir_btype), .fault(fault_pulse), .undef(undef_pulse));
endmodule

// File: tb/auth_ibranch_unit_tb.sv
module auth_ibranch_unit_tb;
  logic clk = 0;
  logic rst = 1;
  logic feat_en = 1, guarded_pg = 0, insn_valid = 0;
  logic [31:0] insn_word = '0;
  logic auth_req_ready = 0, auth_rsp_valid = 0, auth_rsp_pass = 0;
  logic [63:0] auth_rsp_addr = '0;
  logic [63:0] sp_val = 64'h5555_aaaa_0000_8000;
  logic insn_ready, auth_req_valid, auth_key_b, auth_rsp_ready;
  logic redir_valid, fault_pulse, undef_pulse;
  logic [4:0] rs_addr_t, rs_addr_m;
  logic [63:0] rs_data_t, rs_data_m, auth_target, auth_modifier, redir_addr;
  logic [1:0] redir_btype, redir_kind;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  assign rs_data_t = {56'h1111_0000_0000_00, 3'b0, rs_addr_t};
  assign rs_data_m = {56'h2222_0000_0000_00, 3'b0, rs_addr_m};

  auth_ibranch_unit u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit z, input bit m, input logic [4:0] rn, input logic [4:0] rm);
    return {7'b1101011, z, 1'b0, 2'b00, 5'h1f, 4'h0, 1'b1, m, rn, rm};
  endfunction

  task automatic accept(input logic [31:0] w);
    @(negedge clk);
    chk(insn_ready == 1'b1, "R5 idle ready", 64'(insn_ready), 64'd1);
    insn_word = w; insn_valid = 1;
    chk(rs_addr_t == w[9:5] && rs_addr_m == w[4:0], "R10 read addresses",
        64'({rs_addr_t, rs_addr_m}), 64'({w[9:5], w[4:0]}));
    @(negedge clk);
    insn_valid = 0;
  endtask

  task automatic run_branch(input bit z, input bit m, input logic [4:0] rn, input logic [4:0] rm,
                            input bit guard, input int delay, input bit pass);
    logic [63:0] exp_t, exp_m, raddr;
    logic [1:0] exp_bt;
    exp_t = {56'h1111_0000_0000_00, 3'b0, rn};
    exp_m = !z ? 64'd0 : (rm == 5'd31) ? sp_val : {56'h2222_0000_0000_00, 3'b0, rm};
    exp_bt = (guard && rn != 5'd16 && rn != 5'd17) ? 2'b11 : 2'b01;
    raddr = 64'h0000_7fff_0000_1000 + 64'(rn);
    guarded_pg = guard;
    accept(mk(z, m, rn, rm));
    guarded_pg = 0;
    chk(auth_req_valid == 1'b1, "R5 request raised", 64'(auth_req_valid), 64'd1);
    chk(auth_key_b == m, "R2 key select", 64'(auth_key_b), 64'(m));
    chk(auth_target == exp_t, "R10 target", auth_target, exp_t);
    chk(auth_modifier == exp_m, "R3 modifier", auth_modifier, exp_m);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chk(auth_req_valid && auth_target == exp_t && auth_modifier == exp_m && !insn_ready,
          "R5 hold under back-pressure", auth_modifier, exp_m);
    end
    auth_req_ready = 1;
    @(negedge clk);
    auth_req_ready = 0;
    chk(!auth_req_valid && auth_rsp_ready, "R6 waiting for response",
        64'({auth_req_valid, auth_rsp_ready}), 64'b01);
    @(negedge clk);
    chk(auth_rsp_ready == 1'b1, "R6 still waiting", 64'(auth_rsp_ready), 64'd1);
    auth_rsp_valid = 1; auth_rsp_pass = pass; auth_rsp_addr = raddr;
    @(negedge clk);
    auth_rsp_valid = 0;
    if (pass) begin
      chk(redir_valid && !fault_pulse, "R6 redirect issued", 64'(redir_valid), 64'd1);
      chk(redir_addr == raddr, "R6 redirect address", redir_addr, raddr);
      chk(redir_kind == 2'b01, "R6 redirect kind", 64'(redir_kind), 64'd1);
      chk(redir_btype == exp_bt, "R7 branch tag", 64'(redir_btype), 64'(exp_bt));
    end else begin
      chk(fault_pulse && !redir_valid, "R8 fault raised", 64'({fault_pulse, redir_valid}), 64'b10);
    end
    chk(!auth_rsp_ready && insn_ready, "R6 one response taken", 64'(auth_rsp_ready), 64'd0);
    @(negedge clk);
    chk(!redir_valid && !fault_pulse, "R8 single-cycle outcome",
        64'({redir_valid, fault_pulse}), 64'd0);
  endtask

  task automatic run_undef(input logic [31:0] w, input bit fe);
    feat_en = fe;
    accept(w);
    feat_en = 1;
    chk(undef_pulse && !auth_req_valid, "R4 undefined pulse",
        64'({undef_pulse, auth_req_valid}), 64'b10);
    @(negedge clk);
    chk(!undef_pulse && !auth_req_valid && insn_ready, "R4 pulse ends, no request",
        64'({undef_pulse, auth_req_valid}), 64'd0);
  endtask

  task automatic run_foreign(input logic [31:0] w);
    accept(w);
    chk(!auth_req_valid && !undef_pulse && insn_ready, "R1 foreign word ignored",
        64'({auth_req_valid, undef_pulse, insn_ready}), 64'b001);
    @(negedge clk);
    chk(!redir_valid && !fault_pulse && !undef_pulse, "R1 no later output",
        64'({redir_valid, fault_pulse, undef_pulse}), 64'd0);
  endtask

  task automatic run_reset_mid;
    accept(mk(1, 0, 5'd2, 5'd7));
    chk(auth_req_valid == 1'b1, "R9 request pending", 64'(auth_req_valid), 64'd1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(!auth_req_valid && !auth_rsp_ready && insn_ready && !redir_valid && !fault_pulse && !undef_pulse,
        "R9 reset mid-request", 64'({auth_req_valid, insn_ready}), 64'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(insn_ready && !auth_req_valid && !redir_valid && !fault_pulse && !undef_pulse && !auth_rsp_ready,
        "R9 reset state", 64'({insn_ready, auth_req_valid}), 64'b10);
    run_branch(1, 0, 5'd4, 5'd3, 0, 0, 1);
    run_branch(1, 1, 5'd16, 5'd31, 1, 3, 1);
    run_branch(0, 0, 5'd5, 5'd31, 1, 1, 1);
    run_branch(0, 1, 5'd9, 5'd31, 0, 2, 0);
    run_branch(1, 1, 5'd17, 5'd12, 1, 0, 1);
    run_branch(1, 0, 5'd9, 5'd1, 0, 0, 1);
    run_branch(1, 0, 5'd20, 5'd6, 0, 0, 0);
    run_undef(mk(0, 0, 5'd3, 5'd4), 1);
    run_undef(mk(1, 1, 5'd3, 5'd4), 0);
    run_foreign(mk(1, 0, 5'd3, 5'd4) & ~32'h0000_0800);
    run_foreign(mk(1, 0, 5'd3, 5'd4) | 32'h0080_0000);
    run_reset_mid();
    run_branch(1, 1, 5'd8, 5'd2, 1, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule